// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block times a cooling fan by counting reference clock cycles over a chosen number of rising edges on the fan's tachometer signal. While monitoring is enabled, the block waits for a tach edge, counts cycles until the chosen edge count is reached, and stores the elapsed count as a 16-bit result. It then arms again for the next measurement, so the result follows the fan for as long as monitoring stays on.

A slow fan can push the count past its range. In that case the result saturates at all ones. A fan that produces no edge for a full timeout window is reported as stalled, and the result is also forced to all ones.

The 16-bit result is read as two bytes. The low byte is always visible. A read strobe for the low byte captures the high byte of the same result into a holding register, so the two bytes always belong to one measurement.

Top module: `fan_tach_meter`

## Requirements
- R1: The tach input passes through a two-flop synchronizer, and only rising edges are counted. The result equals the number of clock cycles between the detection of the first rising edge and the detection of the final one. For a periodic tach of P cycles and N edges this is (N-1)*P.
- R2: The edge-count setting `edgeTarget` gives the total number of rising edges per measurement, including the first. The values 0 and 1 behave as 2.
- R3: If the elapsed count exceeds 65535 before the final edge, the stored result is FFFFh and the stall flag is 0.
- R4: While monitoring is enabled, 2^TIMEOUT_W consecutive cycles with no rising edge end the activity as a stall. This applies both while waiting for the first edge and in the middle of a measurement. The stall flag becomes 1 and the result becomes FFFFh.
- R5: The stall flag returns to 0 when the next measurement completes with a counted result.
- R6: `cntLsb` always shows result bits 7:0. A one-cycle `readLsb` pulse copies result bits 15:8 into `cntMsb`. `cntMsb` changes at no other time.
- R7: While `startEn` is 0, tach edges are ignored: the result and the stall flag keep their values.
- R8: After reset, the result is 0, `cntMsb` is 0 and the stall flag is 0.
- R9: Measurements repeat while monitoring is enabled. After the tach period changes, the result follows the new period without monitoring being restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| startEn | input | 1 | Monitoring enable |
| edgeTarget | input | EDGE_W | Rising edges per measurement (0 and 1 act as 2) |
| tachIn | input | 1 | Asynchronous fan tachometer signal |
| readLsb | input | 1 | Low-byte read strobe; latches the high byte |
| cntLsb | output | CNT_W/2 | Result low byte |
| cntMsb | output | CNT_W/2 | High byte latched at the last low-byte read |
| stallFlag | output | 1 | Fan stalled |

## Verification
The main function is driven with periodic tach waveforms across a grid of periods and edge counts, and each result is compared with (N-1)*P. This grid tells apart off-by-one errors in the edge counting from errors in the cycle counting. The edge settings 0 and 1 check the clamp to 2. One long period with many edges pushes the count past 16 bits, which separates saturation from wrap-around and from a false stall. Silent tach intervals are applied both before the first edge and mid-measurement to trigger the timeout, and the bench then checks that a later good measurement clears the flag. Changes of period are applied with monitoring enabled and with it disabled, which shows that measurements repeat and that edges are ignored while monitoring is off. A sequence of reads with a high byte that changes between them shows that the high byte moves only on a low-byte read.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_ARM,
    ST_RUN
  } tachState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // clear cycle, edge and idle counters
    logic tickInc;    // advance the saturating cycle counter
    logic edgeInc;    // one more edge after the first
    logic idleClr;    // an edge arrived, restart the idle window
    logic idleInc;    // one more silent cycle
    logic saveCount;  // store the measured count, clear the stall flag
    logic saveStall;  // store all ones, set the stall flag
  } tachCmd_t;

endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tachIn,
  output logic riseOut
);

  logic [STAGES-1:0] stageQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
      prevQ  <= 1'b0;
    end else begin
      stageQ <= {stageQ[STAGES-2:0], tachIn};
      prevQ  <= stageQ[STAGES-1];
    end
  end

  assign riseOut = stageQ[STAGES-1] & ~prevQ;

endmodule

// File: rtl/fan_tach_ctrl.sv
module fan_tach_ctrl
  import fan_tach_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startEn,
  input  logic     rise,
  input  logic     lastInterval,
  input  logic     idleExpired,
  output tachCmd_t cmd
);

  tachState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      ST_OFF: begin
        cmd.clrAll = 1'b1;
        if (startEn) stateD = ST_ARM;
      end
      ST_ARM: begin
        if (!startEn) begin
          cmd.clrAll = 1'b1;
          stateD     = ST_OFF;
        end else if (rise) begin
          cmd.clrAll = 1'b1;
          stateD     = ST_RUN;
        end else if (idleExpired) begin
          cmd.saveStall = 1'b1;
          cmd.clrAll    = 1'b1;
        end else begin
          cmd.idleInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (!startEn) begin
          cmd.clrAll = 1'b1;
          stateD     = ST_OFF;
        end else if (rise && lastInterval) begin
          cmd.saveCount = 1'b1;
          cmd.clrAll    = 1'b1;
          stateD        = ST_ARM;
        end else if (rise) begin
          cmd.tickInc = 1'b1;
          cmd.edgeInc = 1'b1;
          cmd.idleClr = 1'b1;
        end else if (idleExpired) begin
          cmd.saveStall = 1'b1;
          cmd.clrAll    = 1'b1;
          stateD        = ST_ARM;
        end else begin
          cmd.tickInc = 1'b1;
          cmd.idleInc = 1'b1;
        end
      end
      default: stateD = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

  AST_SAVE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.saveCount && cmd.saveStall)); // R4

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |-> (!cmd.saveCount && !cmd.saveStall)); // R7

  AST_SAVE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.saveCount |-> rise); // R1

endmodule

// File: rtl/fan_tach_dp.sv
module fan_tach_dp
  import fan_tach_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int EDGE_W    = 5,
  parameter int TIMEOUT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tachCmd_t          cmd,
  input  logic [EDGE_W-1:0] edgeTarget,
  input  logic              readLsb,
  output logic              lastInterval,
  output logic              idleExpired,
  output logic [CNT_W/2-1:0] cntLsb,
  output logic [CNT_W/2-1:0] cntMsb,
  output logic              stallFlag
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [EDGE_W-1:0] MIN_EDGES = EDGE_W'(2);

  logic [CNT_W-1:0]     tickCnt;
  logic [CNT_W-1:0]     tickNext;
  logic [EDGE_W-1:0]    edgeCnt;
  logic [EDGE_W-1:0]    effTarget;
  logic [TIMEOUT_W-1:0] idleCnt;
  logic [CNT_W-1:0]     resultQ;
  logic [HALF_W-1:0]    msbHold;
  logic                 stallQ;

  assign effTarget    = (edgeTarget < MIN_EDGES) ? MIN_EDGES : edgeTarget;
  assign lastInterval = (edgeCnt + EDGE_W'(1)) == (effTarget - EDGE_W'(1));
  assign idleExpired  = &idleCnt;
  assign tickNext     = (tickCnt == CNT_MAX) ? CNT_MAX : tickCnt + CNT_W'(1);

  // Cycle counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (cmd.clrAll)  tickCnt <= '0;
    else if (cmd.tickInc) tickCnt <= tickNext;
  end

  // Edges seen after the first one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            edgeCnt <= '0;
    else if (cmd.clrAll)  edgeCnt <= '0;
    else if (cmd.edgeInc) edgeCnt <= edgeCnt + EDGE_W'(1);
  end

  // Silent-cycle window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         idleCnt <= '0;
    else if (cmd.clrAll | cmd.idleClr) idleCnt <= '0;
    else if (cmd.idleInc)              idleCnt <= idleCnt + TIMEOUT_W'(1);
  end

  // Result and stall flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      stallQ  <= 1'b0;
    end else if (cmd.saveStall) begin
      resultQ <= CNT_MAX;
      stallQ  <= 1'b1;
    end else if (cmd.saveCount) begin
      resultQ <= tickNext;
      stallQ  <= 1'b0;
    end
  end

  // High byte captured on the low-byte read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        msbHold <= '0;
    else if (readLsb) msbHold <= resultQ[CNT_W-1:HALF_W];
  end

  assign cntLsb    = resultQ[HALF_W-1:0];
  assign cntMsb    = msbHold;
  assign stallFlag = stallQ;

  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stallQ |-> (resultQ == CNT_MAX)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (tickCnt == CNT_MAX && cmd.tickInc && !cmd.clrAll) |=> (tickCnt == CNT_MAX)); // R3

  AST_MSB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !readLsb |=> $stable(msbHold)); // R6

  AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.saveCount && !cmd.saveStall) |=> !stallQ); // R5

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int EDGE_W    = 5,
  parameter int TIMEOUT_W = 16,
  parameter int SYNC_N    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startEn,
  input  logic [EDGE_W-1:0]  edgeTarget,
  input  logic               tachIn,
  input  logic               readLsb,
  output logic [CNT_W/2-1:0] cntLsb,
  output logic [CNT_W/2-1:0] cntMsb,
  output logic               stallFlag
);

  tachCmd_t cmd;
  logic     rise;
  logic     lastInterval;
  logic     idleExpired;

  fan_tach_sync #(.STAGES(SYNC_N)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .tachIn (tachIn),
    .riseOut(rise)
  );

  fan_tach_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startEn     (startEn),
    .rise        (rise),
    .lastInterval(lastInterval),
    .idleExpired (idleExpired),
    .cmd         (cmd)
  );

  fan_tach_dp #(
    .CNT_W    (CNT_W),
    .EDGE_W   (EDGE_W),
    .TIMEOUT_W(TIMEOUT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .edgeTarget  (edgeTarget),
    .readLsb     (readLsb),
    .lastInterval(lastInterval),
    .idleExpired (idleExpired),
    .cntLsb      (cntLsb),
    .cntMsb      (cntMsb),
    .stallFlag   (stallFlag)
  );

endmodule

// File: tb/test_fan_tach_meter.sv
`timescale 1ns/1ps
module test_fan_tach_meter;

  localparam int CNT_W     = 16;
  localparam int EDGE_W    = 5;
  localparam int TIMEOUT_W = 13;
  localparam int TIMEOUT   = 1 << TIMEOUT_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startEn = 1'b0;
  logic [EDGE_W-1:0] edgeTarget = '0;
  logic              tachIn = 1'b0;
  logic              readLsb = 1'b0;
  logic [7:0]        cntLsb;
  logic [7:0]        cntMsb;
  logic              stallFlag;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  int  genPeriod = 10;
  bit  genOn = 0;
  int  genCnt = 0;

  always #2 clk = ~clk;

  fan_tach_meter #(
    .CNT_W(CNT_W), .EDGE_W(EDGE_W), .TIMEOUT_W(TIMEOUT_W)
  ) i_fan_tach_meter (
    .clk(clk), .rstN(rstN), .startEn(startEn), .edgeTarget(edgeTarget),
    .tachIn(tachIn), .readLsb(readLsb), .cntLsb(cntLsb), .cntMsb(cntMsb),
    .stallFlag(stallFlag)
  );

  // Tach generator: exact period of genPeriod cycles, high for the first half
  always @(negedge clk) begin
    if (!genOn) begin
      genCnt = 0;
      tachIn = 1'b0;
    end else begin
      tachIn = (genCnt < genPeriod / 2);
      genCnt = (genCnt + 1 >= genPeriod) ? 0 : genCnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readResult(output int value);
    logic [7:0] lo;
    @(negedge clk);
    lo = cntLsb;
    readLsb = 1'b1;
    @(negedge clk);
    readLsb = 1'b0;
    value = {cntMsb, lo};
  endtask

  function automatic int expected(input int n, input int p);
    int e;
    int d;
    e = (n < 2) ? 2 : n;
    d = (e - 1) * p;
    return (d > 65535) ? 65535 : d;
  endfunction

  // Disable, configure, re-enable and wait for one full measurement
  task automatic measure(input int n, input int p, output int value);
    @(negedge clk);
    startEn = 1'b0;
    genOn = 0;
    waitCycles(4);
    edgeTarget = EDGE_W'(n);
    genPeriod = p;
    genOn = 1;
    startEn = 1'b1;
    waitCycles(2 * ((n < 2 ? 2 : n) + 1) * p + 20);
    readResult(value);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int v;
    int sweepN[4] = '{2, 3, 4, 7};
    int sweepP[3] = '{6, 9, 23};

    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    // R8: reset state
    check("R8 lsb", cntLsb, 0);
    check("R8 msb", cntMsb, 0);
    check("R8 stall", stallFlag, 0);

    // R1: sweep of periods and edge counts
    foreach (sweepN[i]) begin
      foreach (sweepP[j]) begin
        measure(sweepN[i], sweepP[j], v);
        check("R1 count", v, expected(sweepN[i], sweepP[j]));
      end
    end
    check("R1 stall", stallFlag, 0);

    // R2: settings 0 and 1 behave as 2
    measure(0, 10, v);
    check("R2 target0", v, 10);
    measure(1, 13, v);
    check("R2 target1", v, 13);

    // R6: high byte moves only on a low-byte read
    measure(4, 100, v);
    check("R6 value", v, 300);
    check("R6 msb", cntMsb, 1);
    measure(4, 37, v);
    check("R6 second value", v, 111);
    measure(4, 100, v);
    genPeriod = 37;
    waitCycles(2 * 5 * 100 + 20);
    check("R6 msb held before read", cntMsb, 1);
    readResult(v);
    check("R6 msb after read", cntMsb, 0);

    // R3: overflow saturates without a stall
    measure(31, 2200, v);
    check("R3 saturate", v, 65535);
    check("R3 no stall", stallFlag, 0);

    // R4: stall while waiting for the first edge
    @(negedge clk);
    startEn = 1'b0;
    genOn = 0;
    waitCycles(4);
    edgeTarget = EDGE_W'(3);
    genPeriod = 20;
    startEn = 1'b1;
    waitCycles(TIMEOUT - 200);
    check("R4 not yet", stallFlag, 0);
    waitCycles(400);
    check("R4 stall flag", stallFlag, 1);
    readResult(v);
    check("R4 stall value", v, 65535);

    // R5: a good measurement clears the stall
    genOn = 1;
    waitCycles(2 * 4 * 20 + 20);
    check("R5 stall cleared", stallFlag, 0);
    readResult(v);
    check("R5 value", v, 40);

    // R9: period change while enabled is followed
    genPeriod = 12;
    waitCycles(2 * 4 * 20 + 40);
    readResult(v);
    check("R9 new period", v, 24);

    // R7: edges ignored while disabled
    @(negedge clk);
    startEn = 1'b0;
    genPeriod = 30;
    waitCycles(400);
    readResult(v);
    check("R7 result held", v, 24);
    check("R7 stall held", stallFlag, 0);
    startEn = 1'b1;
    waitCycles(2 * 4 * 30 + 40);
    readResult(v);
    check("R7 resumes", v, 60);

    // R4: stall in the middle of a measurement
    genOn = 0;
    waitCycles(TIMEOUT + 400);
    check("R4 mid stall flag", stallFlag, 1);
    readResult(v);
    check("R4 mid stall value", v, 65535);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule